// File: doc/BRIEF.md
# Flash Page Write-Buffer Loader

This block sits between a host write port and a word-wide flash array model and accepts the multi-cycle buffered programming sequence. The host first gives two unlock writes, then a buffer-load command at an address inside the sector it wants to program. Next it writes the number of words to load, minus one, at that same sector. After that come address/data writes into a page buffer that is aligned to its own size and holds up to sixteen words. A final commit command transfers the loaded words into the array.

The transfer merges the data into the array: each loaded word is ANDed into its array location, so a bit can fall from 1 to 0 but never rise. Buffer positions that were not loaded leave their array words unchanged. A count above the buffer size, a data write outside the first page, a data write outside the command sector, or any write other than the commit once all words are loaded stops the sequence and raises an abort flag. Only a reset command clears that flag. The array resets to all ones (erased) and can be read through a combinational read port.

Top module: `flash_wbuf_loader`

## Requirements
- R1: After reset `abort_o` and `done_o` are 0 and every array word reads as all ones (FFFFh).
- R2: The sequence AAh@555h, 55h@2AAh, 25h@SA, (N-1)@SA, N data writes and 29h@SA programs those N words; N may be anything from 1 to 16. `done_o` is 1 in the cycle after the commit write and 0 in the cycle after that.
- R3: A count write whose data exceeds 15 (more than 16 words) sets `abort_o` in the next cycle, and no array word changes.
- R4: A data write whose page bits (address bits 10..4) differ from those of the first data write of the sequence sets `abort_o`.
- R5: A data write whose sector bits (address bits 10..7) differ from those of the buffer-load command address sets `abort_o`.
- R6: While `abort_o` is 1, every write other than one with low byte F0h is ignored, including a complete programming sequence. A write with low byte F0h clears `abort_o` in the next cycle, and a later sequence programs normally.
- R7: The commit stores the AND of the old array word and the loaded word, so no array bit ever changes from 0 to 1.
- R8: Array words of the selected page whose positions were not loaded keep their previous value after commit.
- R9: A second data write to a position already loaded in the same sequence replaces the buffered word and does not consume a count, so that the last value written is the one programmed.
- R10: An unlock prefix with a wrong address or data returns the loader to idle, and the following buffer-load, count, data and commit writes have no effect.
- R11: Once all counted words are loaded, any write that is not 29h in the command sector sets `abort_o`, and nothing is programmed.
- R12: Array contents do not change before the commit write: data writes into the buffer are not visible at the read port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one write per asserted cycle |
| wr_addr | input | ADDR_W (11) | Host write word address |
| wr_data | input | DATA_W (16) | Host write data; commands use the low byte |
| rd_addr | input | ADDR_W (11) | Array read address |
| rd_data | output | DATA_W (16) | Array word at `rd_addr`, combinational |
| abort_o | output | 1 | Sequence aborted; held until a F0h write |
| done_o | output | 1 | One-cycle pulse after a commit merged the buffer |

## Verification
Two things can meet in one cycle. The first is the write that consumes the last count while an earlier-loaded slot is rewritten; the bench loads a slot twice and then finishes the count, and it judges both that the commit is still accepted and that the later value wins. The second is a commit edge that both reads the page buffer into the array and clears the buffer's valid bits. Back-to-back sequences on the same word show whether the second merge saw only its own slots. The bench checks this with an AND-merge expectation on one word and an unchanged-value expectation on its neighbour. Abort entry collides with an otherwise well-formed commit, and that is judged by the absence of `done_o` and an unchanged array.

// File: rtl/flash_wbuf_pkg.sv
package flash_wbuf_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_UNL1,
      ST_UNL2,
      ST_COUNT,
      ST_LOAD,
      ST_FULL,
      ST_ABORT
   } wbuf_state_e;

   localparam logic [7:0] CMD_UNLOCK_1 = 8'hAA;
   localparam logic [7:0] CMD_UNLOCK_2 = 8'h55;
   localparam logic [7:0] CMD_BUF_LOAD = 8'h25;
   localparam logic [7:0] CMD_COMMIT   = 8'h29;
   localparam logic [7:0] CMD_RESET    = 8'hF0;

   localparam int unsigned UNLOCK_ADDR_1 = 32'h555;
   localparam int unsigned UNLOCK_ADDR_2 = 32'h2AA;

endpackage

// File: rtl/wbuf_page_store.sv
module wbuf_page_store #(
   parameter int DATA_W    = 16,
   parameter int BUF_WORDS = 16,
   localparam int OFS_W    = $clog2(BUF_WORDS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clr_i,
   input  logic                        we_i,
   input  logic [OFS_W-1:0]            ofs_i,
   input  logic [DATA_W-1:0]           data_i,
   output logic [BUF_WORDS*DATA_W-1:0] slots_o,
   output logic [BUF_WORDS-1:0]        valid_o,
   output logic                        hit_o
);

   logic [BUF_WORDS-1:0] valid_q;

   for (genvar s = 0; s < BUF_WORDS; s++) begin : g_slot
      logic [DATA_W-1:0] word_q;
      logic              sel;

      assign sel = we_i && (ofs_i == OFS_W'(s));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q     <= '1;
            valid_q[s] <= 1'b0;
         end else if (clr_i) begin
            valid_q[s] <= 1'b0;
         end else if (sel) begin
            word_q     <= data_i;
            valid_q[s] <= 1'b1;
         end
      end

      assign slots_o[s*DATA_W +: DATA_W] = word_q;
   end

   assign valid_o = valid_q;
   assign hit_o   = valid_q[ofs_i];

endmodule

// File: rtl/wbuf_flash_array.sv
module wbuf_flash_array #(
   parameter int ADDR_W    = 11,
   parameter int DATA_W    = 16,
   parameter int BUF_WORDS = 16,
   localparam int OFS_W    = $clog2(BUF_WORDS),
   localparam int PAGE_W   = ADDR_W - OFS_W,
   localparam int DEPTH    = 1 << ADDR_W
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        commit_i,
   input  logic [PAGE_W-1:0]           page_i,
   input  logic [BUF_WORDS*DATA_W-1:0] slots_i,
   input  logic [BUF_WORDS-1:0]        valid_i,
   input  logic [ADDR_W-1:0]           rd_addr_i,
   output logic [DATA_W-1:0]           rd_data_o
);

   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int a = 0; a < DEPTH; a++) begin
            mem_q[a] <= '1;
         end
      end else if (commit_i) begin
         for (int s = 0; s < BUF_WORDS; s++) begin
            if (valid_i[s]) begin
               mem_q[{page_i, OFS_W'(s)}] <=
                  mem_q[{page_i, OFS_W'(s)}] & slots_i[s*DATA_W +: DATA_W];
            end
         end
      end
   end

   assign rd_data_o = mem_q[rd_addr_i];

endmodule

// File: rtl/wbuf_seq_fsm.sv
module wbuf_seq_fsm
   import flash_wbuf_pkg::*;
#(
   parameter int ADDR_W    = 11,
   parameter int DATA_W    = 16,
   parameter int BUF_WORDS = 16,
   parameter int SECT_W    = 4,
   localparam int OFS_W    = $clog2(BUF_WORDS),
   localparam int PAGE_W   = ADDR_W - OFS_W,
   localparam int CNT_W    = OFS_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              slot_hit_i,
   output logic              buf_clr_o,
   output logic              buf_we_o,
   output logic [OFS_W-1:0]  buf_ofs_o,
   output logic              commit_o,
   output logic [PAGE_W-1:0] page_o,
   output logic              abort_o,
   output logic              done_o
);

   wbuf_state_e       state_q, state_d;
   logic [SECT_W-1:0] sect_q, sect_d;
   logic [PAGE_W-1:0] page_q, page_d;
   logic [CNT_W-1:0]  remain_q, remain_d;
   logic              first_q, first_d;
   logic              done_q;

   logic [7:0]        cmd;
   logic [SECT_W-1:0] wr_sect;
   logic [PAGE_W-1:0] wr_page;
   logic              sect_ok;
   logic              count_bad;
   logic              is_unl1;
   logic              is_unl2;

   assign cmd       = wr_data[7:0];
   assign wr_sect   = wr_addr[ADDR_W-1 -: SECT_W];
   assign wr_page   = wr_addr[ADDR_W-1 -: PAGE_W];
   assign sect_ok   = (wr_sect == sect_q);
   assign count_bad = (wr_data > DATA_W'(BUF_WORDS - 1));
   assign is_unl1   = (wr_addr == ADDR_W'(UNLOCK_ADDR_1)) && (cmd == CMD_UNLOCK_1);
   assign is_unl2   = (wr_addr == ADDR_W'(UNLOCK_ADDR_2)) && (cmd == CMD_UNLOCK_2);

   always_comb begin
      state_d   = state_q;
      sect_d    = sect_q;
      page_d    = page_q;
      remain_d  = remain_q;
      first_d   = first_q;
      buf_clr_o = 1'b0;
      buf_we_o  = 1'b0;
      commit_o  = 1'b0;
      if (wr_en) begin
         unique case (state_q)
            ST_IDLE: begin
               if (is_unl1) state_d = ST_UNL1;
            end
            ST_UNL1: begin
               state_d = is_unl2 ? ST_UNL2 : ST_IDLE;
            end
            ST_UNL2: begin
               if (cmd == CMD_BUF_LOAD) begin
                  state_d   = ST_COUNT;
                  sect_d    = wr_sect;
                  buf_clr_o = 1'b1;
               end else begin
                  state_d = ST_IDLE;
               end
            end
            ST_COUNT: begin
               if (!sect_ok || count_bad) begin
                  state_d = ST_ABORT;
               end else begin
                  state_d  = ST_LOAD;
                  remain_d = {1'b0, wr_data[OFS_W-1:0]} + CNT_W'(1);
                  first_d  = 1'b1;
               end
            end
            ST_LOAD: begin
               if (!sect_ok || (!first_q && (wr_page != page_q))) begin
                  state_d = ST_ABORT;
               end else begin
                  buf_we_o = 1'b1;
                  first_d  = 1'b0;
                  if (first_q) page_d = wr_page;
                  if (!slot_hit_i) begin
                     remain_d = remain_q - CNT_W'(1);
                     if (remain_q == CNT_W'(1)) state_d = ST_FULL;
                  end
               end
            end
            ST_FULL: begin
               if (sect_ok && (cmd == CMD_COMMIT)) begin
                  commit_o = 1'b1;
                  state_d  = ST_IDLE;
               end else begin
                  state_d = ST_ABORT;
               end
            end
            ST_ABORT: begin
               if (cmd == CMD_RESET) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         sect_q   <= '0;
         page_q   <= '0;
         remain_q <= '0;
         first_q  <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         state_q  <= state_d;
         sect_q   <= sect_d;
         page_q   <= page_d;
         remain_q <= remain_d;
         first_q  <= first_d;
         done_q   <= commit_o;
      end
   end

   assign buf_ofs_o = wr_addr[OFS_W-1:0];
   assign page_o    = page_q;
   assign abort_o   = (state_q == ST_ABORT);
   assign done_o    = done_q;

endmodule

// File: rtl/flash_wbuf_loader.sv
module flash_wbuf_loader #(
   parameter int ADDR_W    = 11,
   parameter int DATA_W    = 16,
   parameter int BUF_WORDS = 16,
   parameter int SECT_W    = 4,
   localparam int OFS_W    = $clog2(BUF_WORDS),
   localparam int PAGE_W   = ADDR_W - OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              abort_o,
   output logic              done_o
);

   if (ADDR_W < 11) begin : g_chk_addr
      $error("ADDR_W must reach the unlock addresses (>= 11)");
   end
   if (DATA_W < 8) begin : g_chk_data
      $error("DATA_W must carry an 8-bit command");
   end
   if (BUF_WORDS < 2 || (1 << OFS_W) != BUF_WORDS) begin : g_chk_buf
      $error("BUF_WORDS must be a power of two of at least 2");
   end
   if (SECT_W < 1 || SECT_W > PAGE_W) begin : g_chk_sect
      $error("SECT_W must fit above the page offset");
   end

   logic                        buf_clr;
   logic                        buf_we;
   logic [OFS_W-1:0]            buf_ofs;
   logic                        slot_hit;
   logic                        commit;
   logic [PAGE_W-1:0]           page;
   logic [BUF_WORDS*DATA_W-1:0] slots;
   logic [BUF_WORDS-1:0]        valid;

   wbuf_seq_fsm #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .BUF_WORDS(BUF_WORDS),
      .SECT_W   (SECT_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .slot_hit_i(slot_hit),
      .buf_clr_o (buf_clr),
      .buf_we_o  (buf_we),
      .buf_ofs_o (buf_ofs),
      .commit_o  (commit),
      .page_o    (page),
      .abort_o   (abort_o),
      .done_o    (done_o)
   );

   wbuf_page_store #(
      .DATA_W   (DATA_W),
      .BUF_WORDS(BUF_WORDS)
   ) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (buf_clr | commit),
      .we_i   (buf_we),
      .ofs_i  (buf_ofs),
      .data_i (wr_data),
      .slots_o(slots),
      .valid_o(valid),
      .hit_o  (slot_hit)
   );

   wbuf_flash_array #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .BUF_WORDS(BUF_WORDS)
   ) u_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .commit_i (commit),
      .page_i   (page),
      .slots_i  (slots),
      .valid_i  (valid),
      .rd_addr_i(rd_addr),
      .rd_data_o(rd_data)
   );

endmodule

// File: rtl/flash_wbuf_loader_chk.sv
module flash_wbuf_loader_chk #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [7:0]        cmd,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [DATA_W-1:0] rd_data,
   input logic              abort_o,
   input logic              done_o
);

   AST_ABORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_o && !(wr_en && cmd == 8'hF0)) |=> abort_o);                    // R6

   AST_ABORT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_o && wr_en && cmd == 8'hF0) |=> !abort_o);                      // R6

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);                                                   // R2

   AST_DONE_NOT_ABORTED: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !abort_o);                                                  // R3

   AST_ARRAY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(rd_addr) && !done_o) |-> $stable(rd_data));                   // R12

   AST_NO_BIT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(rd_addr) |-> ((rd_data & ~$past(rd_data)) == '0));             // R7

endmodule

bind flash_wbuf_loader flash_wbuf_loader_chk #(
   .ADDR_W(ADDR_W),
   .DATA_W(DATA_W)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .wr_en  (wr_en),
   .cmd    (wr_data[7:0]),
   .rd_addr(rd_addr),
   .rd_data(rd_data),
   .abort_o(abort_o),
   .done_o (done_o)
);

// File: tb/test_flash_wbuf_loader.sv
module test_flash_wbuf_loader;

   localparam int AW = 11;
   localparam int DW = 16;

   typedef struct {
      logic [AW-1:0] addr;
      logic [DW-1:0] exp;
      string         req;
   } exp_item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic          abort_o;
   logic          done_o;

   int  vecs = 0;
   int  errs = 0;
   bit  ended = 1'b0;
   exp_item_t q[$];

   always #10 clk = ~clk;

   flash_wbuf_loader i_flash_wbuf_loader (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .rd_addr(rd_addr),
      .rd_data(rd_data),
      .abort_o(abort_o),
      .done_o (done_o)
   );

   task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      vecs++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: pops expected array words and compares them at the read port
   initial begin
      forever begin
         wait (q.size() > 0);
         @(negedge clk);
         begin
            exp_item_t it;
            it = q.pop_front();
            rd_addr = it.addr;
            #1;
            check(it.req, rd_data, it.exp);
         end
      end
   end

   task automatic expect_word(logic [AW-1:0] a, logic [DW-1:0] v, string req);
      exp_item_t it;
      it.addr = a;
      it.exp  = v;
      it.req  = req;
      q.push_back(it);
   endtask

   task automatic drain();
      wait (q.size() == 0);
      #5;
   endtask

   task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = a;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic wr_last(logic [AW-1:0] a, logic [DW-1:0] d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = a;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic start_seq(logic [AW-1:0] sa, logic [DW-1:0] cnt_m1);
      wr(11'h555, 16'h00AA);
      wr(11'h2AA, 16'h0055);
      wr(sa, 16'h0025);
      wr(sa, cnt_m1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check("R1 abort", {15'd0, abort_o}, 16'h0);
      check("R1 done", {15'd0, done_o}, 16'h0);
      expect_word(11'h100, 16'hFFFF, "R1");
      expect_word(11'h7FF, 16'hFFFF, "R1");
      drain();

      // R2 / R12: six words, nothing visible before commit
      start_seq(11'h100, 16'h0005);
      for (int i = 0; i < 6; i++) wr(11'h100 + AW'(i), 16'h1230 + DW'(i));
      expect_word(11'h100, 16'hFFFF, "R12");
      expect_word(11'h105, 16'hFFFF, "R12");
      drain();
      wr_last(11'h100, 16'h0029);
      check("R2 done", {15'd0, done_o}, 16'h1);
      @(negedge clk);
      check("R2 done one cycle", {15'd0, done_o}, 16'h0);
      for (int i = 0; i < 6; i++) expect_word(11'h100 + AW'(i), 16'h1230 + DW'(i), "R2");
      expect_word(11'h106, 16'hFFFF, "R8");
      expect_word(11'h10F, 16'hFFFF, "R8");
      drain();

      // R7 / R8: single-word AND merge on top of earlier data
      start_seq(11'h100, 16'h0000);
      wr(11'h100, 16'h00FF);
      wr_last(11'h100, 16'h0029);
      check("R7 done", {15'd0, done_o}, 16'h1);
      expect_word(11'h100, 16'h1230 & 16'h00FF, "R7");
      expect_word(11'h101, 16'h1231, "R8");
      drain();

      // R2 boundary: full page of 16 words
      start_seq(11'h480, 16'h000F);
      for (int i = 0; i < 16; i++) wr(11'h480 + AW'(i), 16'hA000 + DW'(i));
      wr_last(11'h480, 16'h0029);
      check("R2 full page done", {15'd0, done_o}, 16'h1);
      expect_word(11'h480, 16'hA000, "R2");
      expect_word(11'h48F, 16'hA00F, "R2");
      drain();

      // R3: count of 17 words aborts
      start_seq(11'h180, 16'h0010);
      check("R3 abort", {15'd0, abort_o}, 16'h1);
      wr(11'h180, 16'h0000);
      wr_last(11'h180, 16'h0029);
      check("R3 no done", {15'd0, done_o}, 16'h0);
      expect_word(11'h180, 16'hFFFF, "R3");
      drain();
      wr(11'h000, 16'h00F0);
      check("R6 cleared after R3", {15'd0, abort_o}, 16'h0);

      // R4: second data write in another page of the same sector
      start_seq(11'h200, 16'h0003);
      wr(11'h200, 16'h0001);
      check("R4 first write ok", {15'd0, abort_o}, 16'h0);
      wr(11'h210, 16'h0002);
      check("R4 abort", {15'd0, abort_o}, 16'h1);
      expect_word(11'h200, 16'hFFFF, "R4");
      drain();
      wr(11'h000, 16'h00F0);

      // R5: data write outside the command sector
      start_seq(11'h200, 16'h0000);
      wr(11'h300, 16'h0003);
      check("R5 abort", {15'd0, abort_o}, 16'h1);
      expect_word(11'h300, 16'hFFFF, "R5");
      drain();

      // R6: a full sequence while aborted is ignored, then F0 clears
      start_seq(11'h280, 16'h0000);
      wr(11'h280, 16'h0000);
      wr_last(11'h280, 16'h0029);
      check("R6 still aborted", {15'd0, abort_o}, 16'h1);
      check("R6 no done", {15'd0, done_o}, 16'h0);
      expect_word(11'h280, 16'hFFFF, "R6");
      drain();
      wr(11'h280, 16'h00F0);
      check("R6 cleared", {15'd0, abort_o}, 16'h0);
      start_seq(11'h280, 16'h0000);
      wr(11'h280, 16'h0F0F);
      wr_last(11'h280, 16'h0029);
      check("R6 program after clear", {15'd0, done_o}, 16'h1);
      expect_word(11'h280, 16'h0F0F, "R6");
      drain();

      // R9: rewrite of a loaded slot does not consume a count
      start_seq(11'h300, 16'h0001);
      wr(11'h300, 16'hAAAA);
      wr(11'h300, 16'h5555);
      wr(11'h301, 16'h1111);
      check("R9 not aborted", {15'd0, abort_o}, 16'h0);
      wr_last(11'h300, 16'h0029);
      check("R9 done", {15'd0, done_o}, 16'h1);
      expect_word(11'h300, 16'h5555, "R9");
      expect_word(11'h301, 16'h1111, "R9");
      drain();

      // R11: non-commit write after the last counted word
      start_seq(11'h380, 16'h0000);
      wr(11'h380, 16'h0001);
      wr(11'h381, 16'h0002);
      check("R11 abort", {15'd0, abort_o}, 16'h1);
      expect_word(11'h380, 16'hFFFF, "R11");
      expect_word(11'h381, 16'hFFFF, "R11");
      drain();
      wr(11'h000, 16'h00F0);

      // R10: broken unlock prefix
      wr(11'h555, 16'h00AA);
      wr(11'h2AA, 16'h0011);
      wr(11'h400, 16'h0025);
      wr(11'h400, 16'h0000);
      wr(11'h400, 16'h0000);
      wr_last(11'h400, 16'h0029);
      check("R10 no done", {15'd0, done_o}, 16'h0);
      check("R10 no abort", {15'd0, abort_o}, 16'h0);
      expect_word(11'h400, 16'hFFFF, "R10");
      drain();

      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         vecs++;
         errs++;
         $display("FAIL watchdog (all requirements) actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
         $finish;
      end
   end

endmodule